// File: doc/BRIEF.md
# Data-Link Status and Interrupt Unit

This block gathers the status of a data-link controller into one readable byte and raises an interrupt from it. The controller's receive path, transmit path and code detector are outside the block. They reach it as single-cycle event pulses and as two occupancy counts, one for each 16-entry byte FIFO. Four status bits record events and stay set until software reads the status register. The other four bits are decoded live from the FIFO occupancy.

Software reaches the block through a small register port. The status register is read-only. The mask register is read-write and has one enable bit per status bit. The active-low interrupt output is asserted while any status bit and its enable are both 1. The register port is a plain control interface with single-cycle access and no back-pressure: a read returns data in the same cycle it is presented, and a write takes effect at the next rising edge.

Top module: `fdl_irq_unit`

## Requirements
- R1: The status byte carries, from bit 7 down to bit 0: code change, packet end, packet start, receive half full, receive not empty, transmit half empty, transmit not full, message end. The mask register uses the same bit positions.
- R2: Status bit 4 is 1 exactly when the receive occupancy is greater than 8 (the FIFO depth is 16).
- R3: Status bit 3 is 1 exactly when the receive occupancy is at least 1.
- R4: Status bit 2 is 1 exactly when the transmit occupancy is below 8. Status bit 1 is 1 exactly when the transmit occupancy is below 16.
- R5: A pulse on an event input sets its status bit (7, 6, 5 or 0) from the next rising edge. The bit then stays set while no status read occurs.
- R6: A read of the status register (address 0x01, with rd high) returns the current value. The event bits are cleared at the rising edge that ends the read. The level bits are not affected.
- R7: If an event pulse and a status read occur in the same cycle, that event bit is set after the edge, so the event is not lost.
- R8: The mask register is at address 0x02. A write stores the data at the rising edge, and a read returns the stored value.
- R9: irq_n is 0 exactly when some status bit and the matching mask bit are both 1. A mask bit of 0 disables that source.
- R10: A write to the status address changes no status bit.
- R11: A read of any address other than 0x01 or 0x02 returns 0 and leaves the event bits unchanged.
- R12: After reset the event bits and the mask register are 0, and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a status read also clears the event bits) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, 0 otherwise |
| ev_code_chg | input | 1 | Code detector changed state |
| ev_pkt_end | input | 1 | Receiver finished a packet |
| ev_pkt_start | input | 1 | Receiver saw an opening flag |
| ev_msg_end | input | 1 | Transmitter finished a message |
| rx_level | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_level | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions assume that both occupancy inputs stay within 0 to the FIFO depth; a level-decoder check flags any value above 16. They also assume that inputs settle between clock edges. The bench meets both assumptions. It only ever drives occupancy values from 0 to 16, and it changes every input on the falling clock edge. It samples the combinational read data and the interrupt shortly after driving, before the next rising edge.

// File: rtl/fdl_irq_pkg.sv
package fdl_irq_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned EV_N   = 4;

  // Field order is MSB first, so the packed layout fixes the bit positions.
  typedef struct packed {
    logic code_chg;   // 7
    logic pkt_end;    // 6
    logic pkt_start;  // 5
    logic rx_half;    // 4
    logic rx_ne;      // 3
    logic tx_half;    // 2
    logic tx_nf;      // 1
    logic msg_end;    // 0
  } fdl_stat_t;

  // Index of each source in the event-latch vector
  localparam int unsigned EV_CODE  = 3;
  localparam int unsigned EV_PEND  = 2;
  localparam int unsigned EV_PSTRT = 1;
  localparam int unsigned EV_MEND  = 0;
endpackage

// File: rtl/fdl_level_decode.sv
module fdl_level_decode #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  output logic             rx_half,
  output logic             rx_ne,
  output logic             tx_half,
  output logic             tx_nf
);
  localparam int unsigned HALF = DEPTH / 2;

  assign rx_half = rx_level > LVL_W'(HALF);
  assign rx_ne   = rx_level != '0;
  assign tx_half = tx_level < LVL_W'(HALF);
  assign tx_nf   = tx_level < LVL_W'(DEPTH);

  // Input assumption: occupancy never exceeds the FIFO depth
  assert_rx_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(DEPTH));
  assert_tx_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(DEPTH));
endmodule

// File: rtl/fdl_event_latch.sv
module fdl_event_latch #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pulse,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else
        q[i] <= (q[i] & ~clr) | pulse[i];
    end

    assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |=> q[i]);
    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !pulse[i]) |=> !q[i]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !pulse[i]) |=> $stable(q[i]));
  end
endmodule

// File: rtl/fdl_reg_port.sv
module fdl_reg_port #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 1,
  parameter int unsigned MASK_ADDR = 2,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] rdata,
  output logic              stat_rd,
  output logic [DATA_W-1:0] mask
);
  logic hit_stat, hit_mask;
  assign hit_stat = addr == ADDR_W'(STAT_ADDR);
  assign hit_mask = addr == ADDR_W'(MASK_ADDR);
  assign stat_rd  = rd && hit_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask <= '0;
    else if (wr && hit_mask)
      mask <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_stat)      rdata = stat;
      else if (hit_mask) rdata = mask;
    end
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit_stat && !hit_mask) |-> (rdata == '0));
  assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_mask) |=> (mask == $past(wdata)));
  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_mask) |=> $stable(mask));
endmodule

// File: rtl/fdl_irq_unit.sv
module fdl_irq_unit
  import fdl_irq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 1,
  parameter int unsigned MASK_ADDR = 2,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ev_code_chg,
  input  logic              ev_pkt_end,
  input  logic              ev_pkt_start,
  input  logic              ev_msg_end,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  output logic              irq_n
);
  fdl_stat_t         stat;
  logic [STAT_W-1:0] stat_vec, mask;
  logic [EV_N-1:0]   ev_pulse, ev_q;
  logic              stat_rd;
  logic              rx_half, rx_ne, tx_half, tx_nf;

  always_comb begin
    ev_pulse           = '0;
    ev_pulse[EV_CODE]  = ev_code_chg;
    ev_pulse[EV_PEND]  = ev_pkt_end;
    ev_pulse[EV_PSTRT] = ev_pkt_start;
    ev_pulse[EV_MEND]  = ev_msg_end;
  end

  fdl_event_latch #(.N(EV_N)) u_events (
    .clk(clk), .rst_n(rst_n), .pulse(ev_pulse), .clr(stat_rd), .q(ev_q)
  );

  fdl_level_decode #(.DEPTH(DEPTH)) u_levels (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_half(rx_half), .rx_ne(rx_ne), .tx_half(tx_half), .tx_nf(tx_nf)
  );

  always_comb begin
    stat.code_chg  = ev_q[EV_CODE];
    stat.pkt_end   = ev_q[EV_PEND];
    stat.pkt_start = ev_q[EV_PSTRT];
    stat.rx_half   = rx_half;
    stat.rx_ne     = rx_ne;
    stat.tx_half   = tx_half;
    stat.tx_nf     = tx_nf;
    stat.msg_end   = ev_q[EV_MEND];
  end
  assign stat_vec = stat;

  fdl_reg_port #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR), .DATA_W(STAT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .stat(stat_vec), .rdata(reg_rdata),
    .stat_rd(stat_rd), .mask(mask)
  );

  assign irq_n = ~|(stat_vec & mask);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n);
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q == '0 && (mask & 8'h1E) == '0) |-> irq_n);
endmodule

// File: tb/test_fdl_irq_unit.sv
`timescale 1ns/1ps
module test_fdl_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ev_code_chg = 1'b0, ev_pkt_end = 1'b0, ev_pkt_start = 1'b0, ev_msg_end = 1'b0;
  logic [4:0] rx_level = '0, tx_level = '0;
  logic       irq_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  fdl_irq_unit i_fdl_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_code_chg(ev_code_chg),
    .ev_pkt_end(ev_pkt_end), .ev_pkt_start(ev_pkt_start), .ev_msg_end(ev_msg_end),
    .rx_level(rx_level), .tx_level(tx_level), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // which = {code_chg, pkt_end, pkt_start, msg_end}
  task automatic pulse_ev(input logic [3:0] which);
    @(negedge clk);
    {ev_code_chg, ev_pkt_end, ev_pkt_start, ev_msg_end} = which;
    @(negedge clk);
    {ev_code_chg, ev_pkt_end, ev_pkt_start, ev_msg_end} = '0;
  endtask

  task automatic set_lv(input logic [4:0] rx, input logic [4:0] tx);
    @(negedge clk); rx_level = rx; tx_level = tx;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(4'h2, d); check("R12 mask reset", d, 8'h00);
    check("R12 irq_n reset", {7'b0, irq_n}, 8'h01);
    rd_reg(4'h1, d); check("R12 status reset", d, 8'h06);
  endtask

  task automatic t_levels;
    logic [7:0] d;
    set_lv(5'd1, 5'd7);  rd_reg(4'h1, d); check("R3 rx=1 tx=7", d, 8'h0E);
    set_lv(5'd8, 5'd8);  rd_reg(4'h1, d); check("R2 rx=8 tx=8", d, 8'h0A);
    set_lv(5'd9, 5'd15); rd_reg(4'h1, d); check("R2 rx=9 tx=15", d, 8'h1A);
    set_lv(5'd16, 5'd16); rd_reg(4'h1, d); check("R4 rx=16 tx=16", d, 8'h18);
    set_lv(5'd0, 5'd16); rd_reg(4'h1, d); check("R3 rx=0", d, 8'h00);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    pulse_ev(4'b1000); repeat (2) @(negedge clk);
    rd_reg(4'h1, d); check("R5 code change held", d, 8'h80);
    rd_reg(4'h1, d); check("R6 cleared by read", d, 8'h00);
    pulse_ev(4'b0110); rd_reg(4'h1, d); check("R1 packet end/start", d, 8'h60);
    pulse_ev(4'b0001); set_lv(5'd12, 5'd16);
    rd_reg(4'h1, d); check("R6 msg end with levels", d, 8'h19);
    rd_reg(4'h1, d); check("R6 levels survive read", d, 8'h18);
    set_lv(5'd0, 5'd16);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk); ev_pkt_start = 1'b1; reg_rd = 1'b1; reg_addr = 4'h1;
    #1 d = reg_rdata; check("R7 old value during read", d, 8'h00);
    @(negedge clk); ev_pkt_start = 1'b0; reg_rd = 1'b0;
    rd_reg(4'h1, d); check("R7 event kept", d, 8'h20);
    rd_reg(4'h1, d); check("R7 later clear", d, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr_reg(4'h2, 8'hA5); rd_reg(4'h2, d); check("R8 mask readback", d, 8'hA5);
    wr_reg(4'h2, 8'h01);
    pulse_ev(4'b0100); #1 check("R9 masked source", {7'b0, irq_n}, 8'h01);
    pulse_ev(4'b0001); #1 check("R9 enabled source", {7'b0, irq_n}, 8'h00);
    rd_reg(4'h1, d); #1 check("R9 released after read", {7'b0, irq_n}, 8'h01);
    wr_reg(4'h2, 8'h08);
    set_lv(5'd3, 5'd16); #1 check("R9 live level irq", {7'b0, irq_n}, 8'h00);
    set_lv(5'd0, 5'd16); #1 check("R9 live level drop", {7'b0, irq_n}, 8'h01);
    wr_reg(4'h2, 8'h00);
  endtask

  task automatic t_ignore;
    logic [7:0] d;
    wr_reg(4'h1, 8'hFF); rd_reg(4'h1, d); check("R10 status write ignored", d, 8'h00);
    rd_reg(4'h2, d); check("R10 mask untouched", d, 8'h00);
    pulse_ev(4'b1000);
    rd_reg(4'h5, d); check("R11 unmapped reads zero", d, 8'h00);
    rd_reg(4'h0, d); check("R11 address 0 reads zero", d, 8'h00);
    rd_reg(4'h1, d); check("R11 no side effect", d, 8'h80);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_levels();
    t_sticky();
    t_collide();
    t_mask();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule